// File: doc/BRIEF.md
# Prescaled Timer with Per-Channel Match Actions

This block is a free-running up-counter whose rate is divided down from the system clock by a programmable prescaler. Four comparison channels watch the counter. When the counter reaches a channel's stored value, that channel can do any mix of the following: latch an interrupt flag, make the counter restart from zero, or halt counting. Each channel also drives one output pin. The pin can be left alone, driven low, driven high or inverted on a match.

Software programs the block through a small word-addressed register bus. Writes take effect on the clock edge. Reads are combinational from the address. A single interrupt line reports whether any flag is pending. Flags are cleared by writing ones to them. When the counter rolls over past its maximum value, no flag is raised.

Register map (word addresses): 0 control, 1 prescale limit, 2 prescale count (read only), 3 timer count (read only), 4 match control, 5 pin control, 6 interrupt flags, 8+n match value of channel n. All other addresses read as zero.

Top module: `pstimer`

## Requirements
- R1: After reset, every register reads zero, every match pin is low and the interrupt line is low.
- R2: While control bit 0 is set, the prescale count rises by one on each clock. On the clock where it is at least the prescale limit, it returns to zero and the timer count advances by one. The count rate is therefore clock / (limit + 1).
- R3: The timer count wraps from its all-ones value to zero, and the wrap by itself raises no interrupt flag.
- R4: A channel is compared only in the cycle right after the timer count has taken a new value through counting, so it fires once per count value. If match-control bit 3n is set, a firing sets flag bit n of the flag register.
- R5: If match-control bit 3n+1 is set and the counter advances while it equals match value n, it loads zero instead of value+1. The count sequence is then 0..M.
- R6: If match-control bit 3n+2 is set, a firing clears control bit 0 and blocks the counter step on that clock, so the count stays at M. When a stop and a software write land on the same edge, the stop wins.
- R7: Pin-control bits [2n+1:2n] select the action of pin n on a firing: 0 keep, 1 drive low, 2 drive high, 3 invert. Bits [8+n] read back pin n and preset it on a write. A firing with a non-keep action overrides a preset on the same edge.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A firing on the same edge keeps the bit set.
- R9: The interrupt output is high exactly when any flag bit is set.
- R10: Control bit 1 holds both counts at zero. With bits 0 and 1 both clear, the counts keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| match_out | output | NUM_CH | Match pins, one per channel |
| irq | output | 1 | OR of all interrupt flags |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8), four channels and a 32-bit data bus. The narrow counter brings the all-ones rollover within a few hundred clocks, so the no-interrupt-on-wrap rule can be checked directly. Prescale limits of 0, 2 and 3 exercise the once-per-value comparison window, which matters only when a count value lasts longer than one clock.

// File: rtl/pstimer_pkg.sv
package pstimer_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_PRESCALE = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_PCOUNT   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_TCOUNT   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_MCTL     = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_PINCTL   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_FLAGS    = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_MATCH0   = 4'd8;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_LOW  = 2'd1,
    PIN_HIGH = 2'd2,
    PIN_FLIP = 2'd3
  } pin_act_e;
endpackage

// File: rtl/pstimer_count.sv
module pstimer_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hold,
  input  logic             stop_now,
  input  logic             load_zero,
  input  logic [CNT_W-1:0] pr_val,
  output logic [CNT_W-1:0] pc_q,
  output logic [CNT_W-1:0] tc_q,
  output logic             fresh_q
);
  logic [CNT_W-1:0] pc_d;
  logic [CNT_W-1:0] tc_d;
  logic             fresh_d;
  logic             at_limit;

  assign at_limit = (pc_q >= pr_val);

  always_comb begin
    pc_d    = pc_q;
    tc_d    = tc_q;
    fresh_d = 1'b0;
    if (hold) begin
      pc_d = '0;
      tc_d = '0;
    end else if (run && !stop_now) begin
      if (at_limit) begin
        pc_d    = '0;
        tc_d    = load_zero ? '0 : tc_q + 1'b1;
        fresh_d = 1'b1;
      end else begin
        pc_d = pc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      tc_q    <= '0;
      fresh_q <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      tc_q    <= tc_d;
      fresh_q <= fresh_d;
    end
  end
endmodule

// File: rtl/pstimer_match.sv
module pstimer_match
  import pstimer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tc,
  input  logic             fresh,
  input  logic             mr_we,
  input  logic [CNT_W-1:0] mr_wdata,
  input  logic             int_en,
  input  logic             rst_en,
  input  logic             stop_en,
  input  pin_act_e         act,
  input  logic             pin_we,
  input  logic             pin_wdata,
  input  logic             flag_clr,
  output logic             hit,
  output logic             stop_req,
  output logic             zero_req,
  output logic             flag_q,
  output logic             pin_q,
  output logic [CNT_W-1:0] mr_q
);
  logic             equal;
  logic             flag_d;
  logic             pin_d;
  logic [CNT_W-1:0] mr_d;

  assign equal    = (tc == mr_q);
  assign hit      = fresh && equal;
  assign stop_req = hit && stop_en;
  assign zero_req = equal && rst_en;

  always_comb begin
    mr_d = mr_we ? mr_wdata : mr_q;

    flag_d = flag_q;
    if (hit && int_en) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end

    pin_d = pin_we ? pin_wdata : pin_q;
    if (hit) begin
      case (act)
        PIN_LOW:  pin_d = 1'b0;
        PIN_HIGH: pin_d = 1'b1;
        PIN_FLIP: pin_d = ~pin_q;
        default:  pin_d = pin_we ? pin_wdata : pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q   <= '0;
      flag_q <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      mr_q   <= mr_d;
      flag_q <= flag_d;
      pin_q  <= pin_d;
    end
  end
endmodule

// File: rtl/pstimer.sv
module pstimer
  import pstimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] match_out,
  output logic              irq
);
  localparam int MCTL_W = 3 * NUM_CH;
  localparam int PACT_W = 2 * NUM_CH;

  // reset: asserted at once, released after two clocks
  logic rst_meta;
  logic rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  // configuration registers
  logic              ctl_en,  ctl_en_d;
  logic              ctl_hold, ctl_hold_d;
  logic [CNT_W-1:0]  pr_q,    pr_d;
  logic [MCTL_W-1:0] mctl_q,  mctl_d;
  logic [PACT_W-1:0] pact_q,  pact_d;

  logic [CNT_W-1:0]  cnt_pc;
  logic [CNT_W-1:0]  cnt_tc;
  logic              cnt_fresh;

  logic [NUM_CH-1:0] hit_vec;
  logic [NUM_CH-1:0] stop_vec;
  logic [NUM_CH-1:0] zero_vec;
  logic [NUM_CH-1:0] flag_vec;
  logic [CNT_W-1:0]  mr_arr [NUM_CH];
  logic              stop_any;
  logic              zero_any;

  logic wr_ctrl, wr_pr, wr_mctl, wr_pact, wr_flags;
  logic wdata_unused;

  assign wr_ctrl  = bus_wr && (bus_addr == ADR_CTRL);
  assign wr_pr    = bus_wr && (bus_addr == ADR_PRESCALE);
  assign wr_mctl  = bus_wr && (bus_addr == ADR_MCTL);
  assign wr_pact  = bus_wr && (bus_addr == ADR_PINCTL);
  assign wr_flags = bus_wr && (bus_addr == ADR_FLAGS);
  assign wdata_unused = ^bus_wdata;

  assign stop_any = |stop_vec;
  assign zero_any = |zero_vec;

  always_comb begin
    ctl_en_d   = wr_ctrl ? bus_wdata[0] : ctl_en;
    ctl_hold_d = wr_ctrl ? bus_wdata[1] : ctl_hold;
    if (stop_any) begin
      ctl_en_d = 1'b0;
    end
    pr_d   = wr_pr   ? bus_wdata[CNT_W-1:0]  : pr_q;
    mctl_d = wr_mctl ? bus_wdata[MCTL_W-1:0] : mctl_q;
    pact_d = wr_pact ? bus_wdata[PACT_W-1:0] : pact_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ctl_en   <= 1'b0;
      ctl_hold <= 1'b0;
      pr_q     <= '0;
      mctl_q   <= '0;
      pact_q   <= '0;
    end else begin
      ctl_en   <= ctl_en_d;
      ctl_hold <= ctl_hold_d;
      pr_q     <= pr_d;
      mctl_q   <= mctl_d;
      pact_q   <= pact_d;
    end
  end

  pstimer_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync),
    .run      (ctl_en),
    .hold     (ctl_hold),
    .stop_now (stop_any),
    .load_zero(zero_any),
    .pr_val   (pr_q),
    .pc_q     (cnt_pc),
    .tc_q     (cnt_tc),
    .fresh_q  (cnt_fresh)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADR = ADR_MATCH0 + ADDR_W'(g);
    pstimer_match #(.CNT_W(CNT_W)) u_match (
      .clk      (clk),
      .rst_n    (rst_sync),
      .tc       (cnt_tc),
      .fresh    (cnt_fresh),
      .mr_we    (bus_wr && (bus_addr == MY_ADR)),
      .mr_wdata (bus_wdata[CNT_W-1:0]),
      .int_en   (mctl_q[3*g]),
      .rst_en   (mctl_q[3*g+1]),
      .stop_en  (mctl_q[3*g+2]),
      .act      (pin_act_e'(pact_q[2*g +: 2])),
      .pin_we   (wr_pact),
      .pin_wdata(bus_wdata[PACT_W+g]),
      .flag_clr (wr_flags && bus_wdata[g]),
      .hit      (hit_vec[g]),
      .stop_req (stop_vec[g]),
      .zero_req (zero_vec[g]),
      .flag_q   (flag_vec[g]),
      .pin_q    (match_out[g]),
      .mr_q     (mr_arr[g])
    );
  end

  assign irq = |flag_vec;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_CTRL:     bus_rdata[1:0] = {ctl_hold, ctl_en};
      ADR_PRESCALE: bus_rdata = DATA_W'(pr_q);
      ADR_PCOUNT:   bus_rdata = DATA_W'(cnt_pc);
      ADR_TCOUNT:   bus_rdata = DATA_W'(cnt_tc);
      ADR_MCTL:     bus_rdata = DATA_W'(mctl_q);
      ADR_PINCTL: begin
        bus_rdata[PACT_W-1:0]      = pact_q;
        bus_rdata[PACT_W +: NUM_CH] = match_out;
      end
      ADR_FLAGS:    bus_rdata = DATA_W'(flag_vec);
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (bus_addr == ADR_MATCH0 + ADDR_W'(i)) begin
            bus_rdata = DATA_W'(mr_arr[i]);
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/pstimer_chk.sv
module pstimer_chk
  import pstimer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst_sync,
  input logic                bus_wr,
  input logic [3:0]          bus_addr,
  input logic                ctl_en,
  input logic                ctl_hold,
  input logic [CNT_W-1:0]    cnt_pc,
  input logic [CNT_W-1:0]    cnt_tc,
  input logic                stop_any,
  input logic [NUM_CH-1:0]   hit_vec,
  input logic [NUM_CH-1:0]   flag_vec,
  input logic [NUM_CH-1:0]   match_out,
  input logic [2*NUM_CH-1:0] pact_q
);
  AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (!rst_sync)
    ctl_hold |=> (cnt_tc == '0 && cnt_pc == '0)); // R10

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_sync)
    (!ctl_en && !ctl_hold) |=> $stable(cnt_tc)); // R10

  AST_TC_STEP: assert property (@(posedge clk) disable iff (!rst_sync)
    !$stable(cnt_tc) |-> (cnt_tc == '0 || cnt_tc == CNT_W'($past(cnt_tc) + 1'b1))); // R2

  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_sync)
    (stop_any && !ctl_hold) |=> (!ctl_en && $stable(cnt_tc))); // R6

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_sync)
    !(bus_wr && bus_addr == ADR_FLAGS) |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec))); // R8

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
    AST_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_sync)
      $rose(flag_vec[g]) |-> $past(hit_vec[g])); // R3

    AST_PIN_FLIP: assert property (@(posedge clk) disable iff (!rst_sync)
      (hit_vec[g] && pact_q[2*g +: 2] == 2'd3) |=> (match_out[g] != $past(match_out[g]))); // R7
  end
endmodule

bind pstimer pstimer_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_sync (rst_sync),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .ctl_en   (ctl_en),
  .ctl_hold (ctl_hold),
  .cnt_pc   (cnt_pc),
  .cnt_tc   (cnt_tc),
  .stop_any (stop_any),
  .hit_vec  (hit_vec),
  .flag_vec (flag_vec),
  .match_out(match_out),
  .pact_q   (pact_q)
);

// File: tb/sim_pstimer.sv
`timescale 1ns/1ps
module sim_pstimer;
  import pstimer_pkg::*;

  localparam int TW = 8;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int TMAX = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bwr = 1'b0;
  logic [3:0]    badr = ADR_TCOUNT;
  logic [DW-1:0] bwd = '0;
  logic [DW-1:0] rdata;
  logic [NC-1:0] pins;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pstimer #(.CNT_W(TW), .NUM_CH(NC), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bwr), .bus_addr(badr), .bus_wdata(bwd),
    .bus_rdata(rdata), .match_out(pins), .irq(irq)
  );

  // behavioural reference
  int m_pc, m_tc, m_pr, m_mctl, m_pact;
  int m_mr [NC];
  bit m_en, m_hold, m_fresh, m_wrapped;
  bit [NC-1:0] m_flags, m_pins;

  always @(posedge clk or negedge rst_n) begin : ref_model
    bit hit [NC];
    bit stop_any, zero_any, n_fresh;
    int n_pc, n_tc, a;
    bit [NC-1:0] n_flags, n_pins;
    if (!rst_n) begin
      m_pc = 0; m_tc = 0; m_pr = 0; m_mctl = 0; m_pact = 0;
      m_en = 0; m_hold = 0; m_fresh = 0; m_wrapped = 0;
      m_flags = '0; m_pins = '0;
      foreach (m_mr[i]) m_mr[i] = 0;
    end else begin
      stop_any = 0; zero_any = 0;
      for (int i = 0; i < NC; i++) begin
        hit[i] = m_fresh && (m_tc == m_mr[i]);
        if (hit[i] && m_mctl[3*i+2]) stop_any = 1;
        if ((m_tc == m_mr[i]) && m_mctl[3*i+1]) zero_any = 1;
      end
      n_pc = m_pc; n_tc = m_tc; n_fresh = 0;
      if (m_hold) begin
        n_pc = 0; n_tc = 0;
      end else if (m_en && !stop_any) begin
        if (m_pc >= m_pr) begin
          n_pc = 0; n_fresh = 1;
          if (zero_any) n_tc = 0;
          else begin
            if (m_tc == TMAX) m_wrapped = 1;
            n_tc = (m_tc + 1) % (TMAX + 1);
          end
        end else n_pc = m_pc + 1;
      end
      n_flags = m_flags; n_pins = m_pins;
      for (int i = 0; i < NC; i++) begin
        if (hit[i] && m_mctl[3*i]) n_flags[i] = 1;
        else if (bwr && badr == ADR_FLAGS && bwd[i]) n_flags[i] = 0;
        a = (m_pact >> (2*i)) & 3;
        if (hit[i] && a != 0) n_pins[i] = (a == 1) ? 1'b0 : (a == 2) ? 1'b1 : ~m_pins[i];
        else if (bwr && badr == ADR_PINCTL) n_pins[i] = bwd[2*NC+i];
      end
      if (bwr) begin
        if (badr == ADR_CTRL) begin m_en = bwd[0]; m_hold = bwd[1]; end
        if (badr == ADR_PRESCALE) m_pr = int'(bwd[TW-1:0]);
        if (badr == ADR_MCTL) m_mctl = int'(bwd[3*NC-1:0]);
        if (badr == ADR_PINCTL) m_pact = int'(bwd[2*NC-1:0]);
        for (int i = 0; i < NC; i++)
          if (badr == ADR_MATCH0 + 4'(i)) m_mr[i] = int'(bwd[TW-1:0]);
      end
      if (stop_any) m_en = 0;
      m_pc = n_pc; m_tc = n_tc; m_fresh = n_fresh;
      m_flags = n_flags; m_pins = n_pins;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #5;
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
    if (rst_n) begin
      chk("R7 pins", pins, m_pins);
      chk("R9 irq", irq, |m_flags);
      if (!bwr && badr == ADR_TCOUNT) chk("R2 count", rdata, m_tc);
    end
  end

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    bwr = 1; badr = a; bwd = DW'(d);
    @(negedge clk);
    bwr = 0; badr = ADR_TCOUNT; bwd = '0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    @(negedge clk);
    badr = a;
    #5 v = int'(rdata);
    badr = ADR_TCOUNT;
  endtask

  initial begin : stim
    int v, t1, t2, mx;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(ADR_CTRL, v);     chk("R1 ctrl", v, 0);
    rd(ADR_PRESCALE, v); chk("R1 prescale", v, 0);
    rd(ADR_TCOUNT, v);   chk("R1 tcount", v, 0);
    rd(ADR_PINCTL, v);   chk("R1 pinctl", v, 0);
    rd(ADR_FLAGS, v);    chk("R1 flags", v, 0);
    rd(ADR_MATCH0, v);   chk("R1 match0", v, 0);
    chk("R1 pins", pins, 0);
    chk("R1 irq", irq, 0);

    // R2 prescaled rate: limit 2 -> one step every 3 clocks
    wr(ADR_PRESCALE, 2);
    wr(ADR_CTRL, 1);
    repeat (5) @(negedge clk);
    rd(ADR_TCOUNT, t1);
    repeat (8) @(negedge clk);
    rd(ADR_TCOUNT, t2);
    chk("R2 rate", t2 - t1, 3);

    // R10 hold and freeze
    wr(ADR_CTRL, 2);
    repeat (3) @(negedge clk);
    rd(ADR_TCOUNT, v); chk("R10 hold tcount", v, 0);
    rd(ADR_PCOUNT, v); chk("R10 hold pcount", v, 0);
    wr(ADR_CTRL, 1);
    repeat (10) @(negedge clk);
    wr(ADR_CTRL, 0);
    rd(ADR_TCOUNT, t1);
    repeat (5) @(negedge clk);
    rd(ADR_TCOUNT, t2);
    chk("R10 frozen", t2, t1);
    rd(ADR_PCOUNT, v); chk("R10 pcount", v, m_pc);

    // R5 reset on match, R4 interrupt, R9 irq; pin 0 inverts
    wr(ADR_CTRL, 2);
    wr(ADR_PRESCALE, 0);
    wr(ADR_MATCH0, 5);
    wr(ADR_MCTL, 3);
    wr(ADR_PINCTL, 3);
    wr(ADR_CTRL, 1);
    mx = 0;
    for (int i = 0; i < 20; i++) begin
      rd(ADR_TCOUNT, v);
      if (v > mx) mx = v;
    end
    chk("R5 max count", mx, 5);
    rd(ADR_FLAGS, v); chk("R4 flag0", v & 1, 1);
    chk("R9 irq set", irq, 1);

    // R8 write-one-to-clear
    wr(ADR_CTRL, 0);
    wr(ADR_FLAGS, 0);
    rd(ADR_FLAGS, v); chk("R8 zero write", v & 1, 1);
    wr(ADR_FLAGS, 1);
    rd(ADR_FLAGS, v); chk("R8 one write", v, 0);
    chk("R9 irq clear", irq, 0);

    // R7 pin actions: keep, high, low, invert; preset pins 0 and 2
    wr(ADR_CTRL, 2);
    wr(ADR_MCTL, 0);
    wr(ADR_MATCH0 + 4'd1, 3);
    wr(ADR_MATCH0 + 4'd2, 4);
    wr(ADR_MATCH0 + 4'd3, 2);
    wr(ADR_PINCTL, 'h5D8);
    chk("R7 preset", pins, 4'b0101);
    wr(ADR_CTRL, 1);
    repeat (10) @(negedge clk);
    wr(ADR_CTRL, 0);
    chk("R7 actions", pins, 4'b1011);
    rd(ADR_PINCTL, v); chk("R7 readback", (v >> 8) & 15, 11);

    // R4 once per value: limit 3, value 2 lasts 4 clocks, pin inverts once
    wr(ADR_CTRL, 2);
    wr(ADR_PINCTL, 3);
    wr(ADR_MATCH0, 2);
    wr(ADR_PRESCALE, 3);
    wr(ADR_CTRL, 1);
    repeat (16) @(negedge clk);
    wr(ADR_CTRL, 0);
    chk("R4 single firing", pins[0], 1);

    // R6 stop on match
    wr(ADR_CTRL, 2);
    wr(ADR_PRESCALE, 0);
    wr(ADR_MATCH0 + 4'd2, 7);
    wr(ADR_MCTL, 'h100);
    wr(ADR_CTRL, 1);
    repeat (20) @(negedge clk);
    rd(ADR_CTRL, v);   chk("R6 enable cleared", v, 0);
    rd(ADR_TCOUNT, v); chk("R6 stopped at", v, 7);
    repeat (5) @(negedge clk);
    rd(ADR_TCOUNT, v); chk("R6 still", v, 7);

    // R3 wrap with no interrupt
    wr(ADR_CTRL, 2);
    wr(ADR_FLAGS, 15);
    wr(ADR_MCTL, 0);
    wr(ADR_CTRL, 1);
    repeat (300) @(negedge clk);
    chk("R3 wrapped", m_wrapped, 1);
    rd(ADR_FLAGS, v);  chk("R3 no flag", v, 0);
    chk("R3 no irq", irq, 0);
    rd(ADR_TCOUNT, v); chk("R3 count", v, m_tc);

    summary();
  end
endmodule